// File: doc/BRIEF.md
# Packet end gap detector

The block watches the write position of a circular edge-capture buffer and decides when a burst of line activity has finished. Each entry in the buffer stands for one recorded line edge. The block does not hold the buffer. It only looks at where the buffer's writer currently is.

A start pulse arms the block. It captures the current write position, the minimum edge count and the timeout, and it clears its running edge total. From then on the block evaluates once per microsecond tick. Each tick it measures how far the writer has moved since the last activity point.

- A large enough move counts as activity. The block records the tick and the position, and adds the move to the total.
- A long quiet gap after enough edges ends the packet. Edges expected from background counter rollover are removed before the count is judged.
- If the elapsed time passes the timeout, the block stops and reports a timeout instead.

The result is held until the next start.

Top module: `pkt_end_detect`

## Requirements
- R1: After reset `done_o` and `timed_out_o` are 0. A start pulse samples `min_edges_i`, `timeout_i` and `wr_count_i`, clears the edge total, and forces `done_o` and `timed_out_o` to 0 from the next cycle.
- R2: Evaluation happens once per tick of CLKS_PER_TICK clock cycles (default 8). Tick k (k = 1, 2, ...) is evaluated at the k·CLKS_PER_TICK-th rising edge after the edge that sampled start, using the `wr_count_i` value present at that edge. A result shows on the outputs after that edge.
- R3: The new entries at a tick are (wr_count_i − position at last activity) modulo DEPTH. DEPTH defaults to 960, and `wr_count_i` ranges over 0..DEPTH−1, so a wrap from DEPTH−1 to 0 is counted correctly.
- R4: A tick with more than 3 new entries is busy. It sets the activity tick to k and the activity position to `wr_count_i`, and adds the new entries to the total. A tick with 3 or fewer new entries changes none of these, so small moves stay pending against the old position.
- R5: A non-busy tick ends the packet (`done_o`=1, `timed_out_o`=0) when two conditions both hold. First, k minus the activity tick must exceed 20. Second, the total must be at least min_edges + floor(k/256).
- R6: When k exceeds the sampled timeout, the block stops with `done_o`=1 and `timed_out_o`=1. This takes priority over an R5 end on the same tick.
- R7: With a sampled minimum edge count of 0, activity is ignored and the block ends only through R6, at tick timeout+1.
- R8: Once set, `done_o` stays 1 and `timed_out_o` keeps its value until the next start, whatever `wr_count_i` does.
- R9: A start pulse while a measurement is running restarts it from the new sampled values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that arms a new measurement |
| min_edges_i | input | EDGE_W | Minimum edge count for a packet end, 0 disables gap detection |
| timeout_i | input | TIME_W | Timeout in ticks |
| wr_count_i | input | $clog2(DEPTH) | Current write position of the capture buffer |
| done_o | output | 1 | Measurement finished, held until next start |
| timed_out_o | output | 1 | Finish was caused by the timeout, valid while done_o is 1 |

## Verification
The gap-end decision and the timeout can both become true on the same tick. When that happens, the timeout must win and set `timed_out_o`.

This collision is provoked directly with a burst that ends at tick 5. Its quiet gap completes at tick 26, and the bench runs it once with timeout 25 and once with timeout 26. The first run must end at tick 26 flagged as a timeout, and the second at tick 26 flagged as a gap end. Random cases with random timeouts, thresholds, start positions and noise add further coincidences, each judged by a tick-level reference model in the bench.

// File: rtl/gdet_pkg.sv
package gdet_pkg;
  typedef enum logic [1:0] {
    GD_IDLE = 2'd0,
    GD_RUN  = 2'd1,
    GD_DONE = 2'd2
  } gd_state_e;
endpackage

// File: rtl/gdet_tick_gen.sv
module gdet_tick_gen #(
  parameter  int DIV = 8,
  localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic en_i,
  output logic tick_o
);
  logic [CW-1:0] cnt_q;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (en_i)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/gdet_ring_delta.sv
module gdet_ring_delta #(
  parameter int DEPTH = 960,
  parameter int POS_W = $clog2(DEPTH)
) (
  input  logic [POS_W-1:0] cur_i,
  input  logic [POS_W-1:0] ref_i,
  output logic [POS_W-1:0] delta_o
);
  generate
    if (DEPTH == (1 << POS_W)) begin : g_pow2
      // natural wrap of the position width
      assign delta_o = cur_i - ref_i;
    end else begin : g_mod
      logic [POS_W:0] sum;
      always_comb begin
        if (cur_i >= ref_i) sum = {1'b0, cur_i} - {1'b0, ref_i};
        else                sum = {1'b0, cur_i} + (POS_W+1)'(DEPTH) - {1'b0, ref_i};
      end
      assign delta_o = sum[POS_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/gdet_end_judge.sv
module gdet_end_judge #(
  parameter int NOW_W     = 17,
  parameter int TOT_W     = 27,
  parameter int EDGE_W    = 16,
  parameter int CMP_W     = 28,
  parameter int GAP_TICKS = 20,
  parameter int BG_SHIFT  = 8
) (
  input  logic [NOW_W-1:0]  now_i,
  input  logic [NOW_W-1:0]  gap_t_i,
  input  logic [TOT_W-1:0]  total_i,
  input  logic [EDGE_W-1:0] min_i,
  output logic              quiet_o,
  output logic              enough_o
);
  logic [NOW_W-1:0] since;
  logic [CMP_W-1:0] bg, need;

  assign since    = now_i - gap_t_i;
  assign quiet_o  = since > NOW_W'(GAP_TICKS);
  // background rollover entries expected for the elapsed time
  assign bg       = CMP_W'(now_i >> BG_SHIFT);
  assign need     = CMP_W'(min_i) + bg;
  assign enough_o = CMP_W'(total_i) >= need;
endmodule

// File: rtl/pkt_end_detect.sv
module pkt_end_detect
  import gdet_pkg::*;
#(
  parameter  int DEPTH         = 960,
  parameter  int TIME_W        = 16,
  parameter  int EDGE_W        = 16,
  parameter  int CLKS_PER_TICK = 8,
  parameter  int BUSY_THR      = 3,
  parameter  int GAP_TICKS     = 20,
  parameter  int BG_SHIFT      = 8,
  localparam int POS_W         = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [EDGE_W-1:0] min_edges_i,
  input  logic [TIME_W-1:0] timeout_i,
  input  logic [POS_W-1:0]  wr_count_i,
  output logic              done_o,
  output logic              timed_out_o
);
  localparam int NOW_W = TIME_W + 1;
  localparam int TOT_W = TIME_W + POS_W + 1;
  localparam int CMP_W = ((EDGE_W > TOT_W) ? EDGE_W : TOT_W) + 1;

  gd_state_e         state_q;
  logic [NOW_W-1:0]  elapsed_q, gap_t_q, now;
  logic [POS_W-1:0]  gap_pos_q, delta;
  logic [TOT_W-1:0]  total_q;
  logic [EDGE_W-1:0] min_q;
  logic [TIME_W-1:0] tmo_q;
  logic              to_q, tick, busy, quiet, enough, running;

  assign running = (state_q == GD_RUN);
  assign now     = elapsed_q + 1'b1;

  gdet_tick_gen #(.DIV(CLKS_PER_TICK)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(start_i),
    .en_i   (running),
    .tick_o (tick)
  );

  gdet_ring_delta #(.DEPTH(DEPTH), .POS_W(POS_W)) u_delta (
    .cur_i  (wr_count_i),
    .ref_i  (gap_pos_q),
    .delta_o(delta)
  );

  gdet_end_judge #(
    .NOW_W(NOW_W), .TOT_W(TOT_W), .EDGE_W(EDGE_W), .CMP_W(CMP_W),
    .GAP_TICKS(GAP_TICKS), .BG_SHIFT(BG_SHIFT)
  ) u_judge (
    .now_i   (now),
    .gap_t_i (gap_t_q),
    .total_i (total_q),
    .min_i   (min_q),
    .quiet_o (quiet),
    .enough_o(enough)
  );

  assign busy = delta > POS_W'(BUSY_THR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= GD_IDLE;
      elapsed_q <= '0;
      gap_t_q   <= '0;
      gap_pos_q <= '0;
      total_q   <= '0;
      min_q     <= '0;
      tmo_q     <= '0;
      to_q      <= 1'b0;
    end else if (start_i) begin
      state_q   <= GD_RUN;
      elapsed_q <= '0;
      gap_t_q   <= '0;
      gap_pos_q <= wr_count_i;
      total_q   <= '0;
      min_q     <= min_edges_i;
      tmo_q     <= timeout_i;
      to_q      <= 1'b0;
    end else if (running && tick) begin
      elapsed_q <= now;
      if (now > {1'b0, tmo_q}) begin
        // timeout wins over a gap end on the same tick
        state_q <= GD_DONE;
        to_q    <= 1'b1;
      end else if (min_q != '0) begin
        if (busy) begin
          gap_t_q   <= now;
          gap_pos_q <= wr_count_i;
          total_q   <= total_q + TOT_W'(delta);
        end else if (quiet && enough) begin
          state_q <= GD_DONE;
        end
      end
    end
  end

  assign done_o      = (state_q == GD_DONE);
  assign timed_out_o = to_q;
endmodule

// File: rtl/gdet_chk.sv
module gdet_chk #(
  parameter int NOW_W     = 17,
  parameter int TOT_W     = 27,
  parameter int GAP_TICKS = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             done_o,
  input logic             timed_out_o,
  input logic             running_i,
  input logic             min_zero_i,
  input logic [NOW_W-1:0] elapsed_i,
  input logic [NOW_W-1:0] gap_t_i,
  input logic [TOT_W-1:0] total_i
);
  a_r1_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o && !timed_out_o);

  a_r8_done_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  a_r8_flag_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> $stable(timed_out_o));

  a_r6_flag_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timed_out_o |-> done_o);

  a_r7_min0_timeout_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) && min_zero_i |-> timed_out_o);

  a_r4_total_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_i && !start_i |=> total_i >= $past(total_i));

  a_r5_gap_before_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) && !timed_out_o |-> (elapsed_i - gap_t_i) > NOW_W'(GAP_TICKS));
endmodule

bind pkt_end_detect gdet_chk #(
  .NOW_W(NOW_W), .TOT_W(TOT_W), .GAP_TICKS(GAP_TICKS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .done_o     (done_o),
  .timed_out_o(timed_out_o),
  .running_i  (running),
  .min_zero_i (min_q == '0),
  .elapsed_i  (elapsed_q),
  .gap_t_i    (gap_t_q),
  .total_i    (total_q)
);

// File: tb/tb_pkt_end_detect.sv
`timescale 1ns/1ps
module tb_pkt_end_detect;
  localparam int DEPTH = 960;
  localparam int CPT   = 8;
  localparam int POS_W = $clog2(DEPTH);

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [15:0] min_edges_i = '0, timeout_i = '0;
  logic [POS_W-1:0] wr_count_i = '0;
  logic done_o, timed_out_o;

  int n_chk = 0, n_fail = 0;
  // reference model state
  int m_min, m_tmo, m_gt, m_gpos, m_tot, m_end;
  bit m_done, m_to;

  always #2.5 clk = ~clk;

  pkt_end_detect #(.DEPTH(DEPTH), .CLKS_PER_TICK(CPT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .min_edges_i(min_edges_i), .timeout_i(timeout_i),
    .wr_count_i(wr_count_i), .done_o(done_o), .timed_out_o(timed_out_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ring(input int cur, input int rf);
    return (cur - rf + DEPTH) % DEPTH;
  endfunction

  task automatic m_step(input int k, input int pos);
    int d;
    if (m_done) return;
    if (k > m_tmo) begin
      m_done = 1; m_to = 1; m_end = k;
    end else if (m_min != 0) begin
      d = ring(pos, m_gpos);
      if (d > 3) begin
        m_gt = k; m_gpos = pos; m_tot += d;
      end else if ((k - m_gt) > 20 && m_tot >= m_min + k / 256) begin
        m_done = 1; m_to = 0; m_end = k;
      end
    end
  endtask

  task automatic do_start(input int mn, input int tmo, input int spos);
    wr_count_i  = POS_W'(spos);
    min_edges_i = 16'(mn);
    timeout_i   = 16'(tmo);
    start_i     = 1'b1;
    m_min = mn; m_tmo = tmo; m_gt = 0; m_gpos = spos; m_tot = 0;
    m_done = 0; m_to = 0; m_end = -1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // lead quiet ticks, then nbusy ticks of activity, then quiet (optional noise)
  task automatic run_case(input string req, input int mn, input int tmo, input int spos,
                          input int lead, input int nbusy, input int binc, input bit noise);
    int pos, inc, dut_end;
    bit dut_to;
    pos = spos;
    dut_end = -1; dut_to = 0;
    do_start(mn, tmo, spos);
    check(done_o == 1'b0 && timed_out_o == 1'b0, "R1 start clears", int'(done_o), 0);
    for (int k = 1; k <= tmo + 1; k++) begin
      if (k <= lead) inc = 0;
      else if (k <= lead + nbusy) inc = (binc != 0) ? binc : 4 + int'($urandom % 12);
      else inc = noise ? int'($urandom % 2) : 0;
      pos = (pos + inc) % DEPTH;
      wr_count_i = POS_W'(pos);
      m_step(k, pos);
      repeat (CPT) @(posedge clk);
      @(negedge clk);
      if (done_o && dut_end < 0) begin
        dut_end = k; dut_to = timed_out_o;
      end
      if (m_done || dut_end >= 0) break;
    end
    check(dut_end == m_end, {req, " end tick"}, dut_end, m_end);
    check(dut_to == m_to, {req, " timed_out flag"}, int'(dut_to), int'(m_to));
    // R8: outputs held while the buffer keeps moving
    for (int j = 0; j < 3; j++) begin
      wr_count_i = POS_W'((pos + 50 * (j + 1)) % DEPTH);
      repeat (CPT) @(posedge clk);
    end
    @(negedge clk);
    check(done_o == 1'b1 && timed_out_o == m_to, "R8 result held",
          {30'd0, done_o, timed_out_o}, {30'd0, 1'b1, m_to});
  endtask

  initial begin
    int seed;
    seed = int'($urandom(32'd20240601));
    repeat (3) @(negedge clk);
    check(done_o == 1'b0 && timed_out_o == 1'b0, "R1 reset state",
          {30'd0, done_o, timed_out_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(done_o == 1'b0, "R1 idle after reset", int'(done_o), 0);

    // R7 / R2: no gap detection, exact timeout tick despite activity
    run_case("R7", 0, 50, 100, 0, 10, 0, 1'b1);
    run_case("R2", 0, 13, 7, 0, 0, 0, 1'b0);
    // R4: exactly 3 entries is not busy, 4 is
    run_case("R4 three", 1, 60, 0, 0, 1, 3, 1'b0);
    run_case("R4 four", 4, 60, 0, 0, 1, 4, 1'b0);
    // R3: wrap across end of buffer
    run_case("R3 wrap", 10, 60, 955, 0, 1, 10, 1'b0);
    // R5: threshold equality, then one short
    run_case("R5 equal", 40, 100, 0, 0, 5, 8, 1'b0);
    run_case("R5 short", 41, 100, 0, 0, 5, 8, 1'b0);
    // R5: background correction after 256 ticks
    run_case("R5 bg pass", 9, 400, 0, 300, 1, 10, 1'b0);
    run_case("R5 bg fail", 10, 400, 0, 300, 1, 10, 1'b0);
    // R6: gap end and timeout on the same tick
    run_case("R6 collide", 40, 25, 0, 0, 5, 8, 1'b0);
    run_case("R6 no collide", 40, 26, 0, 0, 5, 8, 1'b0);
    // R9: restart while running
    do_start(5, 100, 0);
    for (int k = 1; k <= 10; k++) begin
      wr_count_i = POS_W'(k * 10);
      repeat (CPT) @(posedge clk);
    end
    @(negedge clk);
    check(done_o == 1'b0, "R9 still running", int'(done_o), 0);
    run_case("R9 restart", 16, 80, 600, 2, 3, 6, 1'b0);
    // random mix
    for (int i = 0; i < 20; i++) begin
      run_case("R5 random", int'($urandom % 60), 30 + int'($urandom % 170),
               int'($urandom % DEPTH), int'($urandom % 10), 1 + int'($urandom % 8),
               0, bit'($urandom % 2));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule